// File: doc/BRIEF.md
# Conditional Relative Jump Unit

This unit resolves one branch decision per clock. It receives a 16-bit instruction word, the address that word was fetched from, and the four processor status flags: carry, zero, negative and overflow. From these it reports three things. The first is whether the word is a relative jump. The second is whether that jump is taken. The third is the address of the next instruction.

A jump word carries a 3-bit condition selector and a signed 10-bit displacement counted in 16-bit words. The displacement is measured from the address that follows the jump. Any word that is not a jump simply advances the program counter by one instruction, which is two bytes. A jump whose condition fails does the same.

The decision is made combinationally from the inputs. It is captured in output registers on the rising clock edge, so every result appears one cycle after its inputs were presented. An active-low asynchronous reset clears all three outputs.

Top module: `jmp_unit`

## Requirements
- R1: `is_jump_o` is 1 exactly when bits 15:13 of the instruction word equal 3'b001; the condition selector is bits 12:10 and the displacement is bits 9:0.
- R2: Selector 3'b000 is taken when the zero flag is 0, and selector 3'b001 is taken when the zero flag is 1.
- R3: Selector 3'b010 is taken when the carry flag is 0, and selector 3'b011 is taken when the carry flag is 1.
- R4: Selector 3'b100 is taken when the negative flag is 1 and not taken when it is 0; no selector tests for a clear negative flag.
- R5: Selector 3'b101 is taken when negative equals overflow (signed greater-or-equal), and selector 3'b110 is taken when they differ (signed less-than).
- R6: Selector 3'b111 is taken regardless of the flags.
- R7: A taken jump gives `next_pc_o` = address + 2 + 2 × sign-extended displacement, modulo 2^16, for displacements from −512 to +511 words. For example, word 0x3FF3 at address 0xC028 gives 0xC010.
- R8: A non-jump word gives `taken_o` = 0. A non-jump word or an untaken jump gives `next_pc_o` = address + 2, modulo 2^16.
- R9: The outputs change only on the rising clock edge and reflect the inputs sampled at that edge. While `rst_ni` is low, all three outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_i | input | 16 | Instruction word to resolve |
| addr_i | input | 16 | Byte address of the instruction word |
| flag_c_i | input | 1 | Carry flag |
| flag_z_i | input | 1 | Zero flag |
| flag_n_i | input | 1 | Negative flag |
| flag_v_i | input | 1 | Overflow flag |
| is_jump_o | output | 1 | Registered: word is in jump format |
| taken_o | output | 1 | Registered: jump taken |
| next_pc_o | output | 16 | Registered: address of the next instruction |

## Verification
The assertions check on every cycle that:
- jump-format detection follows the top three bits;
- a non-jump word is never taken;
- the untaken path always lands on the following word;
- a taken result always lands on the sign-extended word-scaled target;
- the unconditional, negative-only and signed greater-or-equal selectors follow their flags;
- reset holds all outputs at zero.

The bench's scenarios are needed for the rest. Each selector is driven under all sixteen flag combinations. The displacement is exercised at its extremes of +511 and −512. The target is made to wrap past both ends of the 16-bit address space. The bench also applies the fixed example of word 0x3FF3 at 0xC028, and asserts reset in the middle of a run.

// File: rtl/jmp_pkg.sv
package jmp_pkg;
  localparam int unsigned COND_W = 3;
  localparam int unsigned NCOND  = 1 << COND_W;
  localparam logic [2:0]  JMP_CLASS = 3'b001;

  typedef enum logic [COND_W-1:0] {
    C_ZCLR  = 3'b000,
    C_ZSET  = 3'b001,
    C_CCLR  = 3'b010,
    C_CSET  = 3'b011,
    C_NSET  = 3'b100,
    C_SGE   = 3'b101,
    C_SLT   = 3'b110,
    C_ALWAYS = 3'b111
  } cond_e;

  typedef struct packed {
    logic c;
    logic z;
    logic n;
    logic v;
  } flags_t;

  function automatic logic cond_met(cond_e sel, flags_t f);
    logic r;
    case (sel)
      C_ZCLR:   r = ~f.z;
      C_ZSET:   r = f.z;
      C_CCLR:   r = ~f.c;
      C_CSET:   r = f.c;
      C_NSET:   r = f.n;
      C_SGE:    r = ~(f.n ^ f.v);
      C_SLT:    r = f.n ^ f.v;
      C_ALWAYS: r = 1'b1;
      default:  r = 1'b0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/jmp_decode.sv
module jmp_decode
  import jmp_pkg::*;
#(
  parameter int unsigned INSTR_W = 16,
  parameter int unsigned OFF_W   = 10
) (
  input  logic [INSTR_W-1:0] instr_i,
  output logic               is_jump_o,
  output cond_e              cond_o,
  output logic [OFF_W-1:0]   offset_o
);
  assign is_jump_o = (instr_i[INSTR_W-1 -: 3] == JMP_CLASS);
  assign cond_o    = cond_e'(instr_i[OFF_W +: COND_W]);
  assign offset_o  = instr_i[OFF_W-1:0];
endmodule

// File: rtl/jmp_cond_eval.sv
module jmp_cond_eval
  import jmp_pkg::*;
(
  input  cond_e  cond_i,
  input  flags_t flags_i,
  output logic   hit_o
);
  logic [NCOND-1:0] hit_vec;

  // every selector evaluated in parallel; late select by the cond field
  for (genvar k = 0; k < NCOND; k++) begin : g_cond
    assign hit_vec[k] = cond_met(cond_e'(COND_W'(k)), flags_i);
  end

  assign hit_o = hit_vec[cond_i];
endmodule

// File: rtl/jmp_target_calc.sv
module jmp_target_calc #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned OFF_W  = 10
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [OFF_W-1:0]  offset_i,
  output logic [ADDR_W-1:0] seq_pc_o,
  output logic [ADDR_W-1:0] tgt_pc_o
);
  localparam int unsigned EXT_W = ADDR_W - OFF_W - 1;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(2);

  logic [ADDR_W-1:0] disp;

  assign disp     = {{EXT_W{offset_i[OFF_W-1]}}, offset_i, 1'b0};
  assign seq_pc_o = addr_i + STEP;
  assign tgt_pc_o = addr_i + STEP + disp;
endmodule

// File: rtl/jmp_unit.sv
module jmp_unit
  import jmp_pkg::*;
#(
  parameter int unsigned INSTR_W = 16,
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned OFF_W   = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               flag_c_i,
  input  logic               flag_z_i,
  input  logic               flag_n_i,
  input  logic               flag_v_i,
  output logic               is_jump_o,
  output logic               taken_o,
  output logic [ADDR_W-1:0]  next_pc_o
);
  logic              dec_jump;
  cond_e             dec_cond;
  logic [OFF_W-1:0]  dec_off;
  logic              cond_hit;
  logic              take_d;
  logic [ADDR_W-1:0] seq_pc;
  logic [ADDR_W-1:0] tgt_pc;
  flags_t            flags;

  assign flags = '{c: flag_c_i, z: flag_z_i, n: flag_n_i, v: flag_v_i};

  jmp_decode #(.INSTR_W(INSTR_W), .OFF_W(OFF_W)) u_dec (
    .instr_i  (instr_i),
    .is_jump_o(dec_jump),
    .cond_o   (dec_cond),
    .offset_o (dec_off)
  );

  jmp_cond_eval u_cond (
    .cond_i (dec_cond),
    .flags_i(flags),
    .hit_o  (cond_hit)
  );

  jmp_target_calc #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_tgt (
    .addr_i  (addr_i),
    .offset_i(dec_off),
    .seq_pc_o(seq_pc),
    .tgt_pc_o(tgt_pc)
  );

  assign take_d = dec_jump & cond_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      is_jump_o <= 1'b0;
      taken_o   <= 1'b0;
      next_pc_o <= '0;
    end else begin
      is_jump_o <= dec_jump;
      taken_o   <= take_d;
      next_pc_o <= take_d ? tgt_pc : seq_pc;
    end
  end
endmodule

// File: rtl/jmp_unit_chk.sv
module jmp_unit_chk #(
  parameter int unsigned INSTR_W = 16,
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned OFF_W   = 10
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [INSTR_W-1:0] instr_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic               flag_n_i,
  input logic               flag_v_i,
  input logic               is_jump_o,
  input logic               taken_o,
  input logic [ADDR_W-1:0]  next_pc_o
);
  logic past_ok;
  logic in_jump;
  logic [2:0] in_cond;
  logic [ADDR_W-1:0] in_disp;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  assign in_jump = (instr_i[INSTR_W-1 -: 3] == 3'b001);
  assign in_cond = instr_i[OFF_W +: 3];
  assign in_disp = ADDR_W'($signed(instr_i[OFF_W-1:0])) << 1;

  AST_JUMP_FORMAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> is_jump_o == $past(in_jump)); // R1

  AST_NEG_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(in_jump && in_cond == 3'b100)) |-> taken_o == $past(flag_n_i)); // R4

  AST_SIGNED_GE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(in_jump && in_cond == 3'b101))
      |-> taken_o == ($past(flag_n_i) == $past(flag_v_i))); // R5

  AST_ALWAYS_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(in_jump && in_cond == 3'b111)) |-> taken_o); // R6

  AST_TAKEN_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && taken_o) |-> next_pc_o == $past(addr_i) + ADDR_W'(2) + $past(in_disp)); // R7

  AST_NONJUMP_NOT_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_jump_o |-> !taken_o); // R8

  AST_SEQ_PC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && !taken_o) |-> next_pc_o == $past(addr_i) + ADDR_W'(2)); // R8

  AST_RESET_CLEAR: assert property (@(posedge clk_i)
    !rst_ni |-> (!is_jump_o && !taken_o && next_pc_o == '0)); // R9
endmodule

bind jmp_unit jmp_unit_chk #(.INSTR_W(INSTR_W), .ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .instr_i  (instr_i),
  .addr_i   (addr_i),
  .flag_n_i (flag_n_i),
  .flag_v_i (flag_v_i),
  .is_jump_o(is_jump_o),
  .taken_o  (taken_o),
  .next_pc_o(next_pc_o)
);

// File: tb/jmp_unit_test.sv
`timescale 1ns/1ps
module jmp_unit_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] instr = '0;
  logic [15:0] addr = '0;
  logic        fc = 0, fz = 0, fn = 0, fv = 0;
  logic        is_jump, taken;
  logic [15:0] next_pc;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  jmp_unit uut (
    .clk_i(clk), .rst_ni(rst_ni), .instr_i(instr), .addr_i(addr),
    .flag_c_i(fc), .flag_z_i(fz), .flag_n_i(fn), .flag_v_i(fv),
    .is_jump_o(is_jump), .taken_o(taken), .next_pc_o(next_pc)
  );

  // behavioural reference
  function automatic void model(input logic [15:0] w, input logic [15:0] a,
                                input bit c, input bit z, input bit n, input bit v,
                                output bit ej, output bit et, output logic [15:0] ep);
    int off, cnd, pc;
    bit hit;
    ej  = (w >> 13) == 1;
    cnd = (w >> 10) & 7;
    off = w & 1023;
    if (off >= 512) off = off - 1024;
    case (cnd)
      0: hit = !z;
      1: hit = z;
      2: hit = !c;
      3: hit = c;
      4: hit = n;
      5: hit = (n == v);
      6: hit = (n != v);
      default: hit = 1;
    endcase
    et = ej && hit;
    pc = int'(a) + 2 + (et ? 2 * off : 0);
    pc = ((pc % 65536) + 65536) % 65536;
    ep = pc[15:0];
  endfunction

  function automatic string tag_for(input logic [15:0] w);
    if ((w >> 13) != 1) return "R1 R8";
    case ((w >> 10) & 7)
      0, 1: return "R2 R7 R8";
      2, 3: return "R3 R7 R8";
      4:    return "R4 R7 R8";
      5, 6: return "R5 R7 R8";
      default: return "R6 R7";
    endcase
  endfunction

  task automatic compare(input string tag, input bit ej, input bit et, input logic [15:0] ep);
    checks++;
    if (is_jump !== ej || taken !== et || next_pc !== ep) begin
      fails++;
      $display("FAIL %s: got jump=%0b taken=%0b pc=%h, expected jump=%0b taken=%0b pc=%h",
               tag, is_jump, taken, next_pc, ej, et, ep);
    end
  endtask

  // drive at negedge, result registered at posedge, sample at next negedge (R9)
  task automatic step(input logic [15:0] w, input logic [15:0] a, input logic [3:0] f,
                      input string tag);
    bit ej, et;
    logic [15:0] ep;
    instr = w; addr = a; {fc, fz, fn, fv} = f;
    model(w, a, f[3], f[2], f[1], f[0], ej, et, ep);
    @(negedge clk);
    compare(tag, ej, et, ep);
  endtask

  initial begin
    #4000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    compare("R9 reset", 0, 0, 16'h0000);
    rst_ni = 1'b1;

    // fixed example R7
    step(16'h3FF3, 16'hC028, 4'b0000, "R7 example");
    checks++;
    if (next_pc !== 16'hC010) begin
      fails++;
      $display("FAIL R7 example: got %h expected c010", next_pc);
    end

    // every selector against every flag combination
    for (int cd = 0; cd < 8; cd++) begin
      for (int f = 0; f < 16; f++) begin
        logic [15:0] w;
        w = 16'h2000 | 16'(cd << 10) | 16'h0005;
        step(w, 16'h1234, 4'(f), tag_for(w));
      end
    end

    // R4: no selector taken for clear N when other selectors fail
    step(16'h3000, 16'h0100, 4'b0000, "R4 N clear");

    // displacement extremes and wrap R7
    step(16'h3DFF, 16'h8000, 4'b0000, "R7 plus511");
    step(16'h3E00, 16'h8000, 4'b0000, "R7 minus512");
    step(16'h3C00, 16'h4000, 4'b0000, "R7 zero disp");
    step(16'h3DFF, 16'hFF00, 4'b0000, "R7 wrap high");
    step(16'h3E00, 16'h0010, 4'b0000, "R7 wrap low");
    step(16'h2000, 16'hFFFE, 4'b0100, "R8 untaken wrap");

    // non-jump words R1 R8
    step(16'h1FFF, 16'hFFFE, 4'b1111, "R1 R8 below class");
    step(16'h4000, 16'h0200, 4'b1111, "R1 R8 above class");
    step(16'hFFFF, 16'hC000, 4'b1111, "R1 R8 all ones");
    step(16'h0000, 16'h0000, 4'b0000, "R1 R8 zero word");

    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [15:0] w;
      w = 16'($urandom);
      if (i % 2 == 0) w = (w & 16'h1FFF) | 16'h2000;
      step(w, 16'($urandom), 4'($urandom), tag_for(w));
    end

    // mid-run reset R9
    instr = 16'h3FFF; addr = 16'hABCD; {fc, fz, fn, fv} = 4'b1111;
    #3 rst_ni = 1'b0;
    #2 compare("R9 async clear", 0, 0, 16'h0000);
    @(negedge clk);
    compare("R9 held in reset", 0, 0, 16'h0000);
    rst_ni = 1'b1;
    step(16'h3FFF, 16'hABCD, 4'b0000, "R6 R9 after reset");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule